// File: doc/BRIEF.md
# Timer Compare-Match Output Generator

This block is a single output-compare channel. It picks one of two external free-running timer counts, compares it against a primary compare value, and in the dual-compare modes also against a secondary one. From the matches it drives one output pin according to a 3-bit mode code. There are three single-compare behaviours: set the pin high, clear it low, or invert it on each match. There are also two dual-compare behaviours: one pulse, or a pulse repeated every timer period.

Each pin edge that ends an action raises a sticky interrupt flag. Software clears the flag with a one-cycle strobe. The timing is fixed:

- A one-cycle compare stage sits in front of the output state machine.
- The flag follows the pin change through a two-stage delay line.

Top module: `cmp_out_channel`

## Requirements
- R1: While reset is low, and on the first cycle after reset, the pin is low and the interrupt flag is low.
- R2: With the select input at 0, the channel compares against timer A's count and period. With it at 1, it uses timer B's count and period. The unselected timer has no effect on the pin.
- R3: When the selected count equals the relevant compare value during clock cycle c, the pin shows its new level after rising edge c+2.
- R4: The interrupt flag reads 1 from the second rising edge after the edge at which the pin changed because of a match.
- R5: Mode 3'b001 starts with the pin low. The first primary match drives it high and raises the flag. Mode 3'b010 starts with the pin high, and the first primary match drives it low and raises the flag. In both modes, later matches change nothing until the mode changes.
- R6: Mode 3'b011 starts with the pin low. Every primary match inverts the pin and raises the flag.
- R7: Mode 3'b100 starts low. A primary match drives the pin high. A following secondary match drives it low and raises the flag. After that, no further match changes the pin.
- R8: Mode 3'b101 behaves like mode 3'b100 but re-arms after each falling edge, so the next primary match produces a new pulse without any mode rewrite.
- R9: When the secondary compare value exceeds the selected timer period, a secondary match is ignored and no falling edge is produced.
- R10: The flag stays set until the clear strobe is high at a rising edge. If a set event and the clear strobe fall on the same edge, the flag stays set.
- R11: Mode 3'b000, and the unused codes 3'b110 and 3'b111, hold the pin low. Any change of mode code takes effect at the next edge: the pin goes to the new mode's starting level, the state machine re-arms, and any flag event still in the delay line is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_a_cnt | input | CNT_W | Timer A count |
| tmr_a_per | input | CNT_W | Timer A period value |
| tmr_b_cnt | input | CNT_W | Timer B count |
| tmr_b_per | input | CNT_W | Timer B period value |
| tmr_sel | input | 1 | Time base select (0 = A, 1 = B) |
| mode | input | 3 | Mode code |
| cmp_pri | input | CNT_W | Primary compare value |
| cmp_sec | input | CNT_W | Secondary compare value |
| irq_clr | input | 1 | Flag clear strobe |
| pin_out | output | 1 | Compare output pin |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
Two actions can land on the same edge: the flag set arriving from the end of the delay line, and the software clear strobe. The bench provokes this by holding the clear strobe high in exactly the cycle before the delayed set matures, counting from a known match cycle. It then expects the flag to stay set, and to fall only at the next edge once the set has passed.

A second collision is a mode change while an event is still in the delay line. That case is judged by the flag staying low.

// File: rtl/cmp_pkg.sv
// Shared types for the compare-match output channel.
// Assumes: mode codes are fixed by software convention and must not be renumbered.
package cmp_pkg;

    typedef enum logic [2:0] {
        MD_OFF   = 3'b000,
        MD_SET   = 3'b001,
        MD_CLR   = 3'b010,
        MD_TGL   = 3'b011,
        MD_PULSE = 3'b100,
        MD_TRAIN = 3'b101,
        MD_RSV6  = 3'b110,
        MD_RSV7  = 3'b111
    } cmp_mode_e;

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DONE   = 2'd2
    } cmp_state_e;

endpackage

// File: rtl/cmp_tbase_sel.sv
// Time base selector: routes one of two timer count/period pairs to the compare logic.
// Assumes: both timers run in the same clock domain as this channel.
module cmp_tbase_sel #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] a_cnt,
    input  logic [CNT_W-1:0] a_per,
    input  logic [CNT_W-1:0] b_cnt,
    input  logic [CNT_W-1:0] b_per,
    input  logic             sel,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per
);

    // Pick the count and period of the selected timer.
    always_comb begin
        cnt = sel ? b_cnt : a_cnt;
        per = sel ? b_per : a_per;
    end

endmodule

// File: rtl/cmp_match_stage.sv
// Registered equality detectors for the primary and secondary compare values.
// A secondary compare value beyond the timer period never reports a match.
// Assumes: the counter never exceeds its period in normal use.
module cmp_match_stage #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] pri,
    input  logic [CNT_W-1:0] sec,
    output logic             eq_pri,
    output logic             eq_sec
);

    logic sec_in_range;

    // Qualify the secondary compare value against the period.
    always_comb sec_in_range = (sec <= per);

    // Register both equality results (one cycle of match latency).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_pri <= 1'b0;
            eq_sec <= 1'b0;
        end else begin
            eq_pri <= (cnt == pri);
            eq_sec <= (cnt == sec) && sec_in_range;
        end
    end

endmodule

// File: rtl/cmp_pin_fsm.sv
// Output state machine: turns registered matches into pin levels per mode code.
// Emits a one-cycle event when an action completes. Emits a flush when the mode
// changes or the channel is idle.
// Assumes: eq_pri/eq_sec come from a registered compare stage.
module cmp_pin_fsm
    import cmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       eq_pri,
    input  logic       eq_sec,
    output logic       pin,
    output logic       evt,
    output logic       flush
);

    cmp_mode_e  md;
    cmp_mode_e  md_q;
    cmp_state_e st;
    cmp_state_e st_nx;
    logic       pin_nx;
    logic       chg;
    logic       idle;

    // Decode the mode code and detect a mode change.
    always_comb begin
        md    = cmp_mode_e'(mode);
        chg   = (md != md_q);
        idle  = (md == MD_OFF) || (md == MD_RSV6) || (md == MD_RSV7);
        flush = chg || idle;
    end

    // Next-state, next-pin and event computation.
    always_comb begin
        pin_nx = pin;
        st_nx  = st;
        evt    = 1'b0;
        if (chg) begin
            pin_nx = (md == MD_CLR);
            st_nx  = ST_ARMED;
        end else begin
            case (md)
                MD_SET: begin
                    if (st == ST_ARMED && eq_pri) begin
                        pin_nx = 1'b1;
                        st_nx  = ST_DONE;
                        evt    = 1'b1;
                    end
                end
                MD_CLR: begin
                    if (st == ST_ARMED && eq_pri) begin
                        pin_nx = 1'b0;
                        st_nx  = ST_DONE;
                        evt    = 1'b1;
                    end
                end
                MD_TGL: begin
                    if (eq_pri) begin
                        pin_nx = ~pin;
                        evt    = 1'b1;
                    end
                end
                MD_PULSE, MD_TRAIN: begin
                    if (st == ST_ARMED && eq_pri) begin
                        pin_nx = 1'b1;
                        st_nx  = ST_ACTIVE;
                    end else if (st == ST_ACTIVE && eq_sec) begin
                        pin_nx = 1'b0;
                        st_nx  = (md == MD_TRAIN) ? ST_ARMED : ST_DONE;
                        evt    = 1'b1;
                    end
                end
                default: begin
                    pin_nx = 1'b0;
                    st_nx  = ST_ARMED;
                end
            endcase
        end
    end

    // State, pin and previous-mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin  <= 1'b0;
            st   <= ST_ARMED;
            md_q <= MD_OFF;
        end else begin
            pin  <= pin_nx;
            st   <= st_nx;
            md_q <= md;
        end
    end

endmodule

// File: rtl/cmp_irq_delay.sv
// Interrupt delay line and sticky flag: an event sets the flag LAG edges after
// it is issued. A flush empties the line. A set beats a same-edge clear.
// Assumes: LAG >= 1.
module cmp_irq_delay #(
    parameter int LAG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic flush,
    input  logic clr,
    output logic flag,
    output logic tail
);

    logic [LAG-1:0] sh;

    // Expose the last stage of the delay line.
    always_comb tail = sh[LAG-1];

    // First delay stage takes the event unless flushed.
    always_ff @(posedge clk) begin
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= evt && !flush;
    end

    // Remaining delay stages.
    for (genvar i = 1; i < LAG; i++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n) sh[i] <= 1'b0;
            else        sh[i] <= sh[i-1] && !flush;
        end
    end

    // Sticky flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag <= 1'b0;
        else if (tail && !flush) flag <= 1'b1;
        else if (clr)            flag <= 1'b0;
    end

endmodule

// File: rtl/cmp_out_channel.sv
// Output-compare channel top: time base select, compare stage, pin state
// machine and interrupt delay.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module cmp_out_channel #(
    parameter int CNT_W   = 16,
    parameter int IRQ_LAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tmr_a_cnt,
    input  logic [CNT_W-1:0] tmr_a_per,
    input  logic [CNT_W-1:0] tmr_b_cnt,
    input  logic [CNT_W-1:0] tmr_b_per,
    input  logic             tmr_sel,
    input  logic [2:0]       mode,
    input  logic [CNT_W-1:0] cmp_pri,
    input  logic [CNT_W-1:0] cmp_sec,
    input  logic             irq_clr,
    output logic             pin_out,
    output logic             irq_flag
);

    logic [CNT_W-1:0] sel_cnt;
    logic [CNT_W-1:0] sel_per;
    logic             eq_pri;
    logic             eq_sec;
    logic             pin_evt;
    logic             pipe_flush;
    logic             irq_tail;

    cmp_tbase_sel #(.CNT_W(CNT_W)) u_sel (
        .a_cnt (tmr_a_cnt),
        .a_per (tmr_a_per),
        .b_cnt (tmr_b_cnt),
        .b_per (tmr_b_per),
        .sel   (tmr_sel),
        .cnt   (sel_cnt),
        .per   (sel_per)
    );

    cmp_match_stage #(.CNT_W(CNT_W)) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt    (sel_cnt),
        .per    (sel_per),
        .pri    (cmp_pri),
        .sec    (cmp_sec),
        .eq_pri (eq_pri),
        .eq_sec (eq_sec)
    );

    cmp_pin_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .eq_pri (eq_pri),
        .eq_sec (eq_sec),
        .pin    (pin_out),
        .evt    (pin_evt),
        .flush  (pipe_flush)
    );

    cmp_irq_delay #(.LAG(IRQ_LAG)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (pin_evt),
        .flush (pipe_flush),
        .clr   (irq_clr),
        .flag  (irq_flag),
        .tail  (irq_tail)
    );

endmodule

// File: rtl/cmp_out_channel_chk.sv
// Property checker for cmp_out_channel, attached by bind.
// Assumes: the default IRQ_LAG of 2 (the R4 property uses fixed depths).
module cmp_out_channel_chk #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tmr_a_per,
    input  logic [CNT_W-1:0] tmr_b_per,
    input  logic             tmr_sel,
    input  logic [2:0]       mode,
    input  logic [CNT_W-1:0] cmp_sec,
    input  logic             irq_clr,
    input  logic             pin_out,
    input  logic             irq_flag,
    input  logic             eq_pri,
    input  logic             eq_sec,
    input  logic             irq_tail
);

    logic [CNT_W-1:0] per_sel;

    // Period of the selected time base, rebuilt from the ports.
    always_comb per_sel = tmr_sel ? tmr_b_per : tmr_a_per;

    AST_IDLE_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b000 || mode == 3'b110 || mode == 3'b111) |=> !pin_out); // R11

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag); // R10

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !irq_tail) |=> !irq_flag); // R10

    AST_SET_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b001 && $past(mode) == 3'b001 && pin_out) |=> pin_out); // R5

    AST_TOGGLE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b011 && $past(mode) == 3'b011 && !eq_pri) |=> $stable(pin_out)); // R6

    AST_SEC_BEYOND_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_sec > per_sel) |=> !eq_sec); // R9

    AST_FLAG_AFTER_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> ($past(pin_out, 2) != $past(pin_out, 3))); // R4

endmodule

bind cmp_out_channel cmp_out_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_a_per (tmr_a_per),
    .tmr_b_per (tmr_b_per),
    .tmr_sel   (tmr_sel),
    .mode      (mode),
    .cmp_sec   (cmp_sec),
    .irq_clr   (irq_clr),
    .pin_out   (pin_out),
    .irq_flag  (irq_flag),
    .eq_pri    (eq_pri),
    .eq_sec    (eq_sec),
    .irq_tail  (irq_tail)
);

// File: tb/cmp_out_channel_test.sv
module cmp_out_channel_test;

    localparam int CLK_NS = 10;
    localparam int W      = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] cnt_a, per_a, cnt_b, per_b, pri, sec;
    logic         tsel, clr;
    logic [2:0]   mode;
    logic         pin_out, irq_flag;

    int n_chk = 0;
    int n_bad = 0;

    // reference state built from the requirements
    logic m_eqp, m_eqs, m_pin, m_s1, m_s2, m_flag;
    int   m_st;
    logic [2:0] m_mq;

    always #(CLK_NS/2) clk = ~clk;

    cmp_out_channel #(.CNT_W(W), .IRQ_LAG(2)) uut (
        .clk(clk), .rst_n(rst_n),
        .tmr_a_cnt(cnt_a), .tmr_a_per(per_a),
        .tmr_b_cnt(cnt_b), .tmr_b_per(per_b),
        .tmr_sel(tsel), .mode(mode),
        .cmp_pri(pri), .cmp_sec(sec),
        .irq_clr(clr),
        .pin_out(pin_out), .irq_flag(irq_flag)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_eqp = 0; m_eqs = 0; m_pin = 0; m_s1 = 0; m_s2 = 0; m_flag = 0;
        m_st = 0; m_mq = 3'b000;
    endtask

    // one clock: predict from current inputs, advance, compare outputs
    task automatic tick();
        logic [W-1:0] c, p;
        logic n_eqp, n_eqs, chg, off, fl, evt, np, nf;
        int   ns;
        c = tsel ? cnt_b : cnt_a;
        p = tsel ? per_b : per_a;
        n_eqp = (c == pri);
        n_eqs = (c == sec) && (sec <= p);
        chg = (mode != m_mq);
        off = (mode == 3'd0) || (mode >= 3'd6);
        fl  = chg || off;
        evt = 0; np = m_pin; ns = m_st;
        if (chg) begin
            np = (mode == 3'd2); ns = 0;
        end else begin
            case (mode)
                3'd1: if (m_st == 0 && m_eqp) begin np = 1; ns = 2; evt = 1; end
                3'd2: if (m_st == 0 && m_eqp) begin np = 0; ns = 2; evt = 1; end
                3'd3: if (m_eqp) begin np = !m_pin; evt = 1; end
                3'd4, 3'd5: begin
                    if (m_st == 0 && m_eqp) begin np = 1; ns = 1; end
                    else if (m_st == 1 && m_eqs) begin
                        np = 0; ns = (mode == 3'd5) ? 0 : 2; evt = 1;
                    end
                end
                default: begin np = 0; ns = 0; end
            endcase
        end
        nf = (m_s2 && !fl) ? 1'b1 : (clr ? 1'b0 : m_flag);
        @(posedge clk);
        #1;
        m_s2 = fl ? 1'b0 : m_s1;
        m_s1 = fl ? 1'b0 : evt;
        m_flag = nf; m_pin = np; m_st = ns; m_mq = mode;
        m_eqp = n_eqp; m_eqs = n_eqs;
        check("R3 pin", pin_out, m_pin);
        check("R4 flag", irq_flag, m_flag);
    endtask

    task automatic clear_flag();
        clr = 1; tick(); clr = 0;
    endtask

    task automatic run_a(input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            cnt_a = (cnt_a == per_a) ? '0 : cnt_a + 1'b1;
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        bit saw_high;
        void'($urandom(32'd4321));
        rst_n = 0; cnt_a = 0; per_a = 9; cnt_b = 0; per_b = 7;
        pri = 0; sec = 0; tsel = 0; clr = 0; mode = 3'b000;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 pin in reset", pin_out, 1'b0);
        check("R1 flag in reset", irq_flag, 1'b0);
        rst_n = 1;
        cnt_a = 20; tick();
        check("R1 pin after reset", pin_out, 1'b0);
        check("R1 flag after reset", irq_flag, 1'b0);

        // R3/R4/R5: set-high mode timing
        pri = 5; mode = 3'b001; tick();
        cnt_a = 5; tick();
        check("R3 pin not yet", pin_out, 1'b0);
        cnt_a = 6; tick();
        check("R3 pin high at c+2", pin_out, 1'b1);
        tick();
        check("R4 flag not yet", irq_flag, 1'b0);
        tick();
        check("R4 flag at pin+2", irq_flag, 1'b1);
        clear_flag();
        cnt_a = 5; tick(); cnt_a = 6; repeat (5) tick();
        check("R5 later match keeps high", pin_out, 1'b1);
        check("R5 later match no flag", irq_flag, 1'b0);

        // R5 mirror: clear-low mode starts high
        mode = 3'b010; tick();
        check("R5 clear mode starts high", pin_out, 1'b1);
        cnt_a = 5; tick(); cnt_a = 6; repeat (4) tick();
        check("R5 clear mode goes low", pin_out, 1'b0);
        check("R5 clear mode flag", irq_flag, 1'b1);
        clear_flag();

        // R6: toggle
        mode = 3'b011; tick();
        check("R6 toggle starts low", pin_out, 1'b0);
        cnt_a = 5; tick(); cnt_a = 6; repeat (3) tick();
        check("R6 first toggle", pin_out, 1'b1);
        cnt_a = 5; tick(); cnt_a = 6; repeat (3) tick();
        check("R6 second toggle", pin_out, 1'b0);
        check("R6 toggle flag", irq_flag, 1'b1);

        // R10: set and clear on the same edge
        clear_flag();
        cnt_a = 5; tick(); cnt_a = 6; tick(); tick();
        clr = 1; tick();
        check("R10 set beats clear", irq_flag, 1'b1);
        tick();
        check("R10 clear takes effect", irq_flag, 1'b0);
        clr = 0;

        // R11: mode change drops pending event
        cnt_a = 5; tick(); cnt_a = 6; tick();
        mode = 3'b000; repeat (4) tick();
        check("R11 off pin low", pin_out, 1'b0);
        check("R11 pending event dropped", irq_flag, 1'b0);

        // R2: timer B select
        tsel = 1; pri = 4; cnt_a = 4; cnt_b = 0; tick();
        mode = 3'b001; repeat (4) tick();
        check("R2 timer A ignored", pin_out, 1'b0);
        cnt_b = 4; tick(); cnt_b = 5; tick();
        check("R2 timer B match", pin_out, 1'b1);
        tsel = 0; mode = 3'b000; tick(); clear_flag();

        // R7: single pulse
        pri = 3; sec = 6; cnt_a = 0; mode = 3'b100;
        saw_high = 0;
        for (int i = 0; i < 12; i++) begin
            run_a(1); if (pin_out) saw_high = 1;
        end
        check("R7 pulse seen", saw_high, 1'b1);
        check("R7 pulse ended", pin_out, 1'b0);
        check("R7 falling edge flag", irq_flag, 1'b1);
        clear_flag();
        saw_high = 0;
        for (int i = 0; i < 20; i++) begin
            run_a(1); if (pin_out) saw_high = 1;
        end
        check("R7 no second pulse", saw_high, 1'b0);

        // R8: pulse train re-arms
        mode = 3'b000; tick(); cnt_a = 0; mode = 3'b101; tick(); clear_flag();
        run_a(12); clear_flag();
        saw_high = 0;
        for (int i = 0; i < 10; i++) begin
            run_a(1); if (pin_out) saw_high = 1;
        end
        check("R8 second pulse", saw_high, 1'b1);
        run_a(2);
        check("R8 second flag", irq_flag, 1'b1);

        // R9: secondary beyond period
        sec = 12; clear_flag();
        mode = 3'b100; tick();
        cnt_a = 3; tick(); cnt_a = 12; tick(); tick(); tick(); tick();
        check("R9 no falling edge", pin_out, 1'b1);
        check("R9 no flag", irq_flag, 1'b0);

        // random mix against the reference
        mode = 3'b000; tick();
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 64 == 0) mode = 3'($urandom % 8);
            if ($urandom % 32 == 0) pri = W'($urandom % (per_a + 2));
            if ($urandom % 32 == 0) sec = W'($urandom % (per_a + 4));
            if ($urandom % 50 == 0) tsel = ~tsel;
            clr = ($urandom % 8 == 0);
            tick();
            cnt_a = (cnt_a >= per_a) ? '0 : cnt_a + 1'b1;
            cnt_b = (cnt_b >= per_b) ? '0 : cnt_b + 1'b1;
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule